// File: doc/BRIEF.md
# Timer Interrupt Status and Router

This block sits between a bank of timer channels and the interrupt lines of a chip. Each channel delivers a one-cycle fire pulse together with its configuration: a route field that picks one of the interrupt lines, a trigger type, and an enable. A level-type fire latches a per-channel status bit that holds its line asserted until software clears the bit with a write-1-to-clear strobe. An edge-type fire produces a single-cycle pulse on the routed line and leaves the status bit clear.

A legacy-replacement mode pins channels 0 and 1 to two fixed lines, whatever their route fields say. The same mode governs two external legacy interrupt inputs, one from a periodic interval timer and one from a real-time clock. Outside legacy mode they pass through to those same two lines. Inside legacy mode they are blocked, and an enable output for the interval timer drops. The upper half of the line bank is active low, and the lower half is active high.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset the status register is all zeros, `pit_en_o` is 1, lines 0 to 15 are low and lines 16 to 31 are high.
- R2: A fire on an enabled channel whose `ch_trig_i` bit is 1 (level type) sets status bit i, where bit i belongs to channel i. It holds the routed line asserted until the bit is cleared.
- R3: A fire on an enabled channel whose `ch_trig_i` bit is 0 (edge type) asserts the routed line for exactly one cycle and leaves the status bit at 0.
- R4: A 1 on `sts_w1c_i` bit i clears status bit i and deasserts the channel's line, and a 0 leaves the bit unchanged. A fire in the same cycle as the clear takes priority.
- R5: While a channel's enable or `glb_en_i` is 0, its status bit is held at 0 and its line is not asserted.
- R6: Lines 16 and above idle high and are driven low when asserted. Lines below 16 idle low and are driven high when asserted.
- R7: The 5-bit route field of channel i sits at `ch_route_i[5*i +: 5]` and selects line 0 to 31. Lines shared by several channels are asserted while any of them is active.
- R8: While `legacy_i` is 1, channel 0 drives line 0 and channel 1 drives line 8, regardless of their route fields. Other channels keep their own routes.
- R9: While `legacy_i` is 0, `pit_en_o` is 1. The sampled `ext_pit_i` level also asserts line 0, and the sampled `ext_rtc_i` level also asserts line 8.
- R10: While `legacy_i` is 1, `pit_en_o` is 0 and neither external input reaches lines 0 or 8.
- R11: On leaving legacy mode, line 8 takes the last sampled RTC level at once, line 0 follows the interval-timer input (low while it is low), and `pit_en_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire_i | input | NUM_CH | One-cycle fire pulse per channel |
| ch_route_i | input | NUM_CH*ROUTE_W | Packed route fields, channel i at bits ROUTE_W*i upward |
| ch_trig_i | input | NUM_CH | Trigger type per channel: 1 level, 0 edge |
| ch_en_i | input | NUM_CH | Per-channel enable |
| glb_en_i | input | 1 | Global enable for all channels |
| legacy_i | input | 1 | Legacy-replacement mode select |
| sts_w1c_i | input | NUM_CH | Write-1-to-clear strobe for the status bits |
| ext_pit_i | input | 1 | External interval-timer interrupt level |
| ext_rtc_i | input | 1 | External real-time-clock interrupt level |
| irq_o | output | NUM_LINES | Interrupt line bank, polarity per R6 |
| sts_o | output | NUM_CH | Per-channel status bits |
| pit_en_o | output | 1 | Interval-timer enable, low in legacy mode |

## Verification
Every result in this block comes out of a single register stage. A status change, an edge pulse, a legacy switch or a sampled external level is therefore visible on the outputs right after the first rising edge that follows the stimulus. Routing itself is combinational from the registered state and the current route field. The bench drives inputs on the falling edge and samples on the next falling edge, which puts the check exactly one rising edge after the stimulus. For the edge pulse, one further falling edge confirms that the line has gone back to idle.

// File: rtl/tir_pkg.sv
package tir_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // true when a line index belongs to the inverted (active-low) half
   function automatic logic line_inverted(input int unsigned idx, input int unsigned low_from);
      return idx >= low_from;
   endfunction
endpackage

// File: rtl/tir_channel.sv
module tir_channel
   import tir_pkg::*;
#(
   parameter int unsigned CH_IDX  = 0,
   parameter int unsigned ROUTE_W = 5,
   parameter int unsigned LEG_A   = 0,
   parameter int unsigned LEG_B   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_i,
   input  logic               trig_i,
   input  logic               en_i,
   input  logic               glb_en_i,
   input  logic               clr_i,
   input  logic               legacy_i,
   input  logic [ROUTE_W-1:0] route_i,
   output logic               sts_o,
   output logic               act_o,
   output logic [ROUTE_W-1:0] eff_route_o
);
   localparam logic [ROUTE_W-1:0] FIX_A = ROUTE_W'(LEG_A);
   localparam logic [ROUTE_W-1:0] FIX_B = ROUTE_W'(LEG_B);

   logic live;
   logic sts_q;
   logic pulse_q;

   assign live = en_i & glb_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= live & fire_i & (trig_i == TRIG_EDGE);
         if (!live)
            sts_q <= 1'b0;
         else if (fire_i)
            sts_q <= (trig_i == TRIG_LEVEL);
         else if (clr_i)
            sts_q <= 1'b0;
      end
   end

   assign sts_o = sts_q;
   assign act_o = sts_q | pulse_q;

   generate
      if (CH_IDX == 0) begin : g_fix_a
         assign eff_route_o = legacy_i ? FIX_A : route_i;
      end else if (CH_IDX == 1) begin : g_fix_b
         assign eff_route_o = legacy_i ? FIX_B : route_i;
      end else begin : g_free
         assign eff_route_o = route_i;
      end
   endgenerate

   assert_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> !sts_o && !act_o);
   assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live && fire_i && trig_i |=> sts_o);
   assert_edge_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live && fire_i && !trig_i |=> act_o && !sts_o);
   assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      live && !fire_i && clr_i |=> !sts_o);
   assert_w0_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      live && !fire_i && !clr_i && sts_o |=> sts_o);
endmodule

// File: rtl/tir_line_mux.sv
module tir_line_mux
   import tir_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned ROUTE_W   = 5,
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned LOW_FROM  = 16
) (
   input  logic [NUM_CH-1:0]              act_i,
   input  logic [NUM_CH-1:0][ROUTE_W-1:0] route_i,
   input  logic [NUM_LINES-1:0]           ext_i,
   output logic [NUM_LINES-1:0]           line_o
);
   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         logic hit;
         always_comb begin
            hit = ext_i[l];
            for (int c = 0; c < NUM_CH; c++) begin
               if (act_i[c] && (route_i[c] == ROUTE_W'(l)))
                  hit = 1'b1;
            end
         end
         if (line_inverted(l, LOW_FROM)) begin : g_low
            assign line_o[l] = ~hit;
         end else begin : g_high
            assign line_o[l] = hit;
         end
      end
   endgenerate
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
   import tir_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned ROUTE_W  = 5,
   parameter int unsigned LOW_FROM = 16,
   parameter int unsigned LEG_A    = 0,
   parameter int unsigned LEG_B    = 8,
   localparam int unsigned NUM_LINES = 1 << ROUTE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH-1:0]           fire_i,
   input  logic [NUM_CH*ROUTE_W-1:0]   ch_route_i,
   input  logic [NUM_CH-1:0]           ch_trig_i,
   input  logic [NUM_CH-1:0]           ch_en_i,
   input  logic                        glb_en_i,
   input  logic                        legacy_i,
   input  logic [NUM_CH-1:0]           sts_w1c_i,
   input  logic                        ext_pit_i,
   input  logic                        ext_rtc_i,
   output logic [NUM_LINES-1:0]        irq_o,
   output logic [NUM_CH-1:0]           sts_o,
   output logic                        pit_en_o
);
   generate
      if (NUM_CH < 2) begin : g_chk_ch
         $error("tmr_irq_router: NUM_CH must be at least 2");
      end
      if (LOW_FROM > NUM_LINES) begin : g_chk_low
         $error("tmr_irq_router: LOW_FROM beyond the line bank");
      end
      if (LEG_A >= LOW_FROM || LEG_B >= LOW_FROM || LEG_A == LEG_B) begin : g_chk_leg
         $error("tmr_irq_router: legacy lines must be distinct and active high");
      end
   endgenerate

   logic                        legacy_q;
   logic                        pit_q;
   logic                        rtc_q;
   logic                        pit_en_q;
   logic [NUM_CH-1:0]           act;
   logic [NUM_CH-1:0][ROUTE_W-1:0] eff_route;
   logic [NUM_LINES-1:0]        ext_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         legacy_q <= 1'b0;
         pit_q    <= 1'b0;
         rtc_q    <= 1'b0;
         pit_en_q <= 1'b1;
      end else begin
         legacy_q <= legacy_i;
         pit_q    <= ext_pit_i;
         rtc_q    <= ext_rtc_i;
         pit_en_q <= ~legacy_i;
      end
   end

   assign pit_en_o = pit_en_q;

   always_comb begin
      ext_vec        = '0;
      ext_vec[LEG_A] = pit_q & ~legacy_q;
      ext_vec[LEG_B] = rtc_q & ~legacy_q;
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tir_channel #(
            .CH_IDX (c),
            .ROUTE_W(ROUTE_W),
            .LEG_A  (LEG_A),
            .LEG_B  (LEG_B)
         ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire_i     (fire_i[c]),
            .trig_i     (ch_trig_i[c]),
            .en_i       (ch_en_i[c]),
            .glb_en_i   (glb_en_i),
            .clr_i      (sts_w1c_i[c]),
            .legacy_i   (legacy_q),
            .route_i    (ch_route_i[c*ROUTE_W +: ROUTE_W]),
            .sts_o      (sts_o[c]),
            .act_o      (act[c]),
            .eff_route_o(eff_route[c])
         );
      end
   endgenerate

   tir_line_mux #(
      .NUM_CH   (NUM_CH),
      .ROUTE_W  (ROUTE_W),
      .NUM_LINES(NUM_LINES),
      .LOW_FROM (LOW_FROM)
   ) u_mux (
      .act_i  (act),
      .route_i(eff_route),
      .ext_i  (ext_vec),
      .line_o (irq_o)
   );

   assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en_i |=> &irq_o[NUM_LINES-1:LOW_FROM]);
   assert_pit_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_i |=> !pit_en_o);
   assert_ext_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_i && !glb_en_i |=> !irq_o[LEG_A] && !irq_o[LEG_B]);
   assert_rtc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_i && !glb_en_i |=> irq_o[LEG_B] == $past(ext_rtc_i));
endmodule

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb_top;
   localparam int unsigned NCH = 4;
   localparam int unsigned RW  = 5;
   localparam int unsigned NL  = 32;
   localparam logic [31:0] POL = 32'hFFFF_0000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NCH-1:0]     fire_i = '0;
   logic [NCH*RW-1:0]  ch_route_i = '0;
   logic [NCH-1:0]     ch_trig_i = '1;
   logic [NCH-1:0]     ch_en_i = '1;
   logic               glb_en_i = 1'b1;
   logic               legacy_i = 1'b0;
   logic [NCH-1:0]     sts_w1c_i = '0;
   logic               ext_pit_i = 1'b0;
   logic               ext_rtc_i = 1'b0;
   logic [NL-1:0]      irq_o;
   logic [NCH-1:0]     sts_o;
   logic               pit_en_o;

   int n_run  = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   tmr_irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .ch_route_i(ch_route_i),
      .ch_trig_i(ch_trig_i), .ch_en_i(ch_en_i), .glb_en_i(glb_en_i),
      .legacy_i(legacy_i), .sts_w1c_i(sts_w1c_i), .ext_pit_i(ext_pit_i),
      .ext_rtc_i(ext_rtc_i), .irq_o(irq_o), .sts_o(sts_o), .pit_en_o(pit_en_o)
   );

   function automatic logic [31:0] lines(input logic [31:0] asserted);
      return asserted ^ POL;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_route(input int c, input logic [RW-1:0] r);
      ch_route_i[c*RW +: RW] = r;
   endtask

   task automatic pulse_fire(input logic [NCH-1:0] m);
      fire_i = m;
      step();
      fire_i = '0;
   endtask

   task automatic pulse_clr(input logic [NCH-1:0] m);
      sts_w1c_i = m;
      step();
      sts_w1c_i = '0;
   endtask

   task automatic t_reset();
      chk("R1 status", 32'(sts_o), 32'h0);
      chk("R1 lines", irq_o, lines(32'h0));
      chk("R1 pit_en", 32'(pit_en_o), 32'h1);
   endtask

   task automatic t_level();
      pulse_fire(4'b0100);
      chk("R2 status set", 32'(sts_o), 32'h4);
      chk("R2 line 3 on", irq_o, lines(32'h8));
      step();
      chk("R2 line held", irq_o, lines(32'h8));
   endtask

   task automatic t_w1c();
      pulse_clr(4'b1011);
      chk("R4 write 0 keeps bit", 32'(sts_o), 32'h4);
      pulse_clr(4'b0100);
      chk("R4 cleared", 32'(sts_o), 32'h0);
      chk("R4 line off", irq_o, lines(32'h0));
      fire_i = 4'b0100; sts_w1c_i = 4'b0100;
      step();
      fire_i = '0; sts_w1c_i = '0;
      chk("R4 fire beats clear", 32'(sts_o), 32'h4);
      pulse_clr(4'b0100);
   endtask

   task automatic t_edge();
      ch_trig_i[1] = 1'b0;
      pulse_fire(4'b0010);
      chk("R3 pulse on line 2", irq_o, lines(32'h4));
      chk("R3 status clear", 32'(sts_o), 32'h0);
      step();
      chk("R3 pulse one cycle", irq_o, lines(32'h0));
      ch_trig_i[1] = 1'b1;
   endtask

   task automatic t_disable();
      pulse_fire(4'b0001);
      chk("R5 setup", 32'(sts_o), 32'h1);
      ch_en_i[0] = 1'b0;
      step();
      chk("R5 chan off status", 32'(sts_o), 32'h0);
      chk("R5 chan off line", irq_o, lines(32'h0));
      pulse_fire(4'b0001);
      chk("R5 fire ignored", irq_o, lines(32'h0));
      ch_en_i[0] = 1'b1;
      pulse_fire(4'b0001);
      glb_en_i = 1'b0;
      step();
      chk("R5 global off", 32'(sts_o), 32'h0);
      chk("R5 global off line", irq_o, lines(32'h0));
      glb_en_i = 1'b1;
      step();
   endtask

   task automatic t_polarity();
      pulse_fire(4'b1000);
      chk("R6 line 20 low", irq_o, lines(32'h0010_0000));
      pulse_clr(4'b1000);
      chk("R6 line 20 idle high", irq_o, lines(32'h0));
   endtask

   task automatic t_shared();
      set_route(0, 5'd7); set_route(1, 5'd7);
      pulse_fire(4'b0011);
      chk("R7 shared on", irq_o, lines(32'h80));
      pulse_clr(4'b0001);
      chk("R7 other still on", irq_o, lines(32'h80));
      pulse_clr(4'b0010);
      chk("R7 shared off", irq_o, lines(32'h0));
      set_route(0, 5'd1); set_route(1, 5'd2);
   endtask

   task automatic t_legacy_route();
      set_route(0, 5'd5); set_route(1, 5'd6);
      legacy_i = 1'b1;
      step();
      pulse_fire(4'b0111);
      chk("R8 fixed routes", irq_o, lines(32'h0000_0109));
      pulse_clr(4'b0111);
      legacy_i = 1'b0;
      step();
      set_route(0, 5'd1); set_route(1, 5'd2);
   endtask

   task automatic t_ext_pass();
      ext_pit_i = 1'b1; ext_rtc_i = 1'b1;
      step();
      chk("R9 ext pass", irq_o, lines(32'h0000_0101));
      chk("R9 pit_en", 32'(pit_en_o), 32'h1);
      ext_pit_i = 1'b0; ext_rtc_i = 1'b0;
      step();
   endtask

   task automatic t_legacy_block();
      legacy_i = 1'b1; ext_pit_i = 1'b1; ext_rtc_i = 1'b1;
      step();
      chk("R10 ext blocked", irq_o, lines(32'h0));
      chk("R10 pit_en low", 32'(pit_en_o), 32'h0);
   endtask

   task automatic t_legacy_exit();
      ext_pit_i = 1'b0;
      step();
      legacy_i = 1'b0;
      step();
      chk("R11 line8 restored, line0 low", irq_o, lines(32'h0000_0100));
      chk("R11 pit_en back", 32'(pit_en_o), 32'h1);
      ext_rtc_i = 1'b0;
      step();
   endtask

   initial begin
      set_route(0, 5'd1); set_route(1, 5'd2); set_route(2, 5'd3); set_route(3, 5'd20);
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_level();
      t_w1c();
      t_edge();
      t_disable();
      t_polarity();
      t_shared();
      t_legacy_route();
      t_ext_pass();
      t_legacy_block();
      t_legacy_exit();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule